// File: doc/BRIEF.md
# Flash Sector-Erase Command Controller

This block is the command state machine for a model of a byte-wide parallel NOR flash device. It decodes host write cycles, each given as an address, a data byte and a one-cycle write strobe. It recognises the unlock and command sequences and collects the sectors to erase in a mask. A timed embedded erase then runs over that mask.

After the erase command is accepted, a collection window stays open. During the window the host may name more sectors in any order. Each added sector starts the window again. When the window lapses, the erase runs for a fixed number of cycles. The host can pause it with a suspend command and continue it with a resume command. Resume carries on from the remaining count. The chip-erase command is modelled only as a busy period over every sector, and it cannot be suspended.

The memory array is outside this block. The read path asks it whether to show array data or status data for the sector under the read address. The status outputs report three things: whether the window has lapsed, whether erasing is in progress, and whether the erase is suspended.

Top module: `flash_sector_erase_ctrl`

## Requirements
- R1: After an asynchronous reset (rst_n low), ready is 1, erase_mask is 0, the three status outputs are 0 and rd_status_sel is 0.
- R2: The host writes six cycles in this order: 0xAA at command address 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, then 0x30. Only the low 11 address bits are compared against a command address. The last write's sector is taken from the address bits above bit 10. This sequence opens the window with that sector's mask bit set, and ready stays 1.
- R3: A write whose address or data does not match the next expected step of the sequence returns the block to read-array mode. No sector is loaded.
- R4: While the window is open, a 0x30 write at any address adds that address's sector to the mask and restarts the window. The window lapses WIN_CYC cycles after the last accepted write. From then on, ready is 0 and stat_window_done and stat_erasing are 1.
- R5: While the window is open, a write with data other than 0x30 or 0xB0 clears the mask and returns the block to read-array mode.
- R6: While the erase is running, every write other than 0xB0 is ignored. The mask and busy state are unchanged.
- R7: 0xB0 written while the window is open, at any address, enters the suspended state at the next clock edge. In that state ready is 1, stat_suspended is 1, stat_window_done is 1 and stat_erasing is 0.
- R8: 0xB0 written during a running erase leaves the block busy for SUSP_LAT cycles and then enters the suspended state.
- R9: While a sector operation is open, rd_status_sel is 1 exactly when rd_sector names a sector set in erase_mask.
- R10: A 0x30 write while suspended resumes the erase. Counting every cycle with stat_erasing at 1, the erase takes ERASE_CYC cycles in total, however it is split by suspends. The count is frozen while suspended.
- R11: When the erase ends, ready returns to 1 and erase_mask and all status outputs return to 0.
- R12: If the sixth write is 0x10 at 0x555, a chip erase starts at once: ready is 0 and erase_mask is all ones for ERASE_CYC cycles. 0xB0 has no effect during a chip erase.
- R13: Asserting rst_n during an erase stops it at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_addr | input | 11+SEC_W | Write address: command bits [10:0], sector above |
| wr_data | input | 8 | Write data byte |
| rd_sector | input | SEC_W | Sector field of the current read address |
| ready | output | 1 | 1 when not busy |
| erase_mask | output | NUM_SECT | Sectors selected for erase |
| rd_status_sel | output | 1 | 1 selects status data, 0 selects array data |
| stat_window_done | output | 1 | Collection window has lapsed |
| stat_erasing | output | 1 | Erase in progress |
| stat_suspended | output | 1 | Erase suspended |

## Verification
The assertions assume that wr_en is a single-cycle pulse, with address and data valid in the same cycle. They also assume the timing parameters are at least 2, so a countdown never starts at zero. Every bench write is one strobe cycle followed by one idle cycle. Extra sectors are always added well inside the window, except for the one write that is deliberately timed to land just before the window lapses.

// File: rtl/flash_sector_erase_pkg.sv
package flash_sector_erase_pkg;

    localparam int CMD_ADDR_W = 11;
    localparam logic [CMD_ADDR_W-1:0] UNLOCK_ADDR_A = 11'h555;
    localparam logic [CMD_ADDR_W-1:0] UNLOCK_ADDR_B = 11'h2AA;

    localparam logic [7:0] CODE_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CODE_UNLOCK_B = 8'h55;
    localparam logic [7:0] CODE_SETUP    = 8'h80;
    localparam logic [7:0] CODE_SECTOR   = 8'h30;
    localparam logic [7:0] CODE_CHIP     = 8'h10;
    localparam logic [7:0] CODE_SUSPEND  = 8'hB0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_SETUP,
        ST_UNL3,
        ST_UNL4,
        ST_WINDOW,
        ST_ERASE,
        ST_SPEND,
        ST_SUSP,
        ST_CHIP
    } fsec_state_e;

    typedef struct packed {
        logic at_a;
        logic at_b;
        logic d_aa;
        logic d_55;
        logic d_80;
        logic d_30;
        logic d_10;
        logic d_b0;
    } fsec_cmd_t;

endpackage

// File: rtl/fsec_cmd_decode.sv
module fsec_cmd_decode
    import flash_sector_erase_pkg::*;
#(
    parameter int NUM_SECT = 8,
    parameter int SEC_W    = $clog2(NUM_SECT)
) (
    input  logic [CMD_ADDR_W+SEC_W-1:0] addr,
    input  logic [7:0]                  data,
    output fsec_cmd_t                   cmd,
    output logic [NUM_SECT-1:0]         sec_bit
);

    localparam int ADDR_W = CMD_ADDR_W + SEC_W;

    logic [SEC_W-1:0] sec_idx;

    always_comb begin
        sec_idx  = addr[ADDR_W-1 -: SEC_W];
        cmd.at_a = (addr[CMD_ADDR_W-1:0] == UNLOCK_ADDR_A);
        cmd.at_b = (addr[CMD_ADDR_W-1:0] == UNLOCK_ADDR_B);
        cmd.d_aa = (data == CODE_UNLOCK_A);
        cmd.d_55 = (data == CODE_UNLOCK_B);
        cmd.d_80 = (data == CODE_SETUP);
        cmd.d_30 = (data == CODE_SECTOR);
        cmd.d_10 = (data == CODE_CHIP);
        cmd.d_b0 = (data == CODE_SUSPEND);
    end

    // one-hot sector select; indexes past NUM_SECT select nothing
    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sec
        assign sec_bit[g] = (sec_idx == SEC_W'(g));
    end

endmodule

// File: rtl/fsec_countdown.sv
module fsec_countdown #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             run,
    output logic             last
);

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = run && (cnt_q == WIDTH'(1));

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (!run && !load) |=> $stable(cnt_q)); // R10
    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (run && !load && cnt_q == '0) |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/fsec_status_view.sv
module fsec_status_view
    import flash_sector_erase_pkg::*;
#(
    parameter int NUM_SECT = 8,
    parameter int SEC_W    = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  fsec_state_e         st,
    input  logic [NUM_SECT-1:0] mask,
    input  logic [SEC_W-1:0]    rd_sector,
    output logic                ready,
    output logic                rd_status_sel,
    output logic                stat_window_done,
    output logic                stat_erasing,
    output logic                stat_suspended
);

    logic [NUM_SECT-1:0] rd_bit;
    logic                op_open;

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_rd
        assign rd_bit[g] = (rd_sector == SEC_W'(g));
    end

    always_comb begin
        stat_erasing     = (st == ST_ERASE) || (st == ST_SPEND) || (st == ST_CHIP);
        stat_suspended   = (st == ST_SUSP);
        stat_window_done = stat_erasing || stat_suspended;
        ready            = !stat_erasing;
        op_open          = stat_window_done || (st == ST_WINDOW);
        rd_status_sel    = op_open && ((rd_bit & mask) != '0);
    end

    AST_IDLE_ARRAY_READ: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_IDLE) |-> !rd_status_sel); // R9

endmodule

// File: rtl/flash_sector_erase_ctrl.sv
module flash_sector_erase_ctrl
    import flash_sector_erase_pkg::*;
#(
    parameter int NUM_SECT  = 8,
    parameter int SEC_W     = $clog2(NUM_SECT),
    parameter int WIN_CYC   = 40,
    parameter int ERASE_CYC = 200,
    parameter int SUSP_LAT  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [CMD_ADDR_W+SEC_W-1:0] wr_addr,
    input  logic [7:0]                  wr_data,
    input  logic [SEC_W-1:0]            rd_sector,
    output logic                        ready,
    output logic [NUM_SECT-1:0]         erase_mask,
    output logic                        rd_status_sel,
    output logic                        stat_window_done,
    output logic                        stat_erasing,
    output logic                        stat_suspended
);

    localparam int WIN_W = $clog2(WIN_CYC + 1);
    localparam int ER_W  = $clog2(ERASE_CYC + 1);
    localparam int SL_W  = $clog2(SUSP_LAT + 1);

    typedef struct packed {
        fsec_state_e         st;
        logic [NUM_SECT-1:0] mask;
    } ctrl_t;

    ctrl_t               ctrl_d, ctrl_q;
    fsec_cmd_t           cmd;
    logic [NUM_SECT-1:0] sec_bit;
    logic                win_load, win_run, win_last;
    logic                er_load, er_run, er_last;
    logic                sl_load, sl_run, sl_last;

    fsec_cmd_decode #(
        .NUM_SECT (NUM_SECT),
        .SEC_W    (SEC_W)
    ) u_decode (
        .addr    (wr_addr),
        .data    (wr_data),
        .cmd     (cmd),
        .sec_bit (sec_bit)
    );

    fsec_countdown #(.WIDTH(WIN_W)) u_win_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (win_load),
        .load_val (WIN_W'(WIN_CYC)),
        .run      (win_run),
        .last     (win_last)
    );

    fsec_countdown #(.WIDTH(ER_W)) u_erase_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (er_load),
        .load_val (ER_W'(ERASE_CYC)),
        .run      (er_run),
        .last     (er_last)
    );

    fsec_countdown #(.WIDTH(SL_W)) u_susp_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sl_load),
        .load_val (SL_W'(SUSP_LAT)),
        .run      (sl_run),
        .last     (sl_last)
    );

    always_comb begin
        win_run = (ctrl_q.st == ST_WINDOW);
        er_run  = (ctrl_q.st == ST_ERASE) || (ctrl_q.st == ST_SPEND) || (ctrl_q.st == ST_CHIP);
        sl_run  = (ctrl_q.st == ST_SPEND);
    end

    always_comb begin
        ctrl_d   = ctrl_q;
        win_load = 1'b0;
        er_load  = 1'b0;
        sl_load  = 1'b0;
        unique case (ctrl_q.st)
            ST_IDLE: begin
                if (wr_en && cmd.at_a && cmd.d_aa) begin
                    ctrl_d.st = ST_UNL1;
                end
            end
            ST_UNL1: begin
                if (wr_en) begin
                    ctrl_d.st = (cmd.at_b && cmd.d_55) ? ST_UNL2 : ST_IDLE;
                end
            end
            ST_UNL2: begin
                if (wr_en) begin
                    ctrl_d.st = (cmd.at_a && cmd.d_80) ? ST_SETUP : ST_IDLE;
                end
            end
            ST_SETUP: begin
                if (wr_en) begin
                    ctrl_d.st = (cmd.at_a && cmd.d_aa) ? ST_UNL3 : ST_IDLE;
                end
            end
            ST_UNL3: begin
                if (wr_en) begin
                    ctrl_d.st = (cmd.at_b && cmd.d_55) ? ST_UNL4 : ST_IDLE;
                end
            end
            ST_UNL4: begin
                if (wr_en) begin
                    if (cmd.d_30) begin
                        ctrl_d.st   = ST_WINDOW;
                        ctrl_d.mask = sec_bit;
                        win_load    = 1'b1;
                    end else if (cmd.at_a && cmd.d_10) begin
                        ctrl_d.st   = ST_CHIP;
                        ctrl_d.mask = '1;
                        er_load     = 1'b1;
                    end else begin
                        ctrl_d.st = ST_IDLE;
                    end
                end
            end
            ST_WINDOW: begin
                if (wr_en) begin
                    if (cmd.d_30) begin
                        ctrl_d.mask = ctrl_q.mask | sec_bit;
                        win_load    = 1'b1;
                    end else if (cmd.d_b0) begin
                        ctrl_d.st = ST_SUSP;
                        er_load   = 1'b1;
                    end else begin
                        ctrl_d.st   = ST_IDLE;
                        ctrl_d.mask = '0;
                    end
                end else if (win_last) begin
                    ctrl_d.st = ST_ERASE;
                    er_load   = 1'b1;
                end
            end
            ST_ERASE: begin
                if (er_last) begin
                    ctrl_d.st   = ST_IDLE;
                    ctrl_d.mask = '0;
                end else if (wr_en && cmd.d_b0) begin
                    ctrl_d.st = ST_SPEND;
                    sl_load   = 1'b1;
                end
            end
            ST_SPEND: begin
                if (er_last) begin
                    ctrl_d.st   = ST_IDLE;
                    ctrl_d.mask = '0;
                end else if (sl_last) begin
                    ctrl_d.st = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (wr_en && cmd.d_30) begin
                    ctrl_d.st = ST_ERASE;
                end
            end
            ST_CHIP: begin
                if (er_last) begin
                    ctrl_d.st   = ST_IDLE;
                    ctrl_d.mask = '0;
                end
            end
            default: begin
                ctrl_d.st   = ST_IDLE;
                ctrl_d.mask = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.st   <= ST_IDLE;
            ctrl_q.mask <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign erase_mask = ctrl_q.mask;

    fsec_status_view #(
        .NUM_SECT (NUM_SECT),
        .SEC_W    (SEC_W)
    ) u_view (
        .clk              (clk),
        .rst_n            (rst_n),
        .st               (ctrl_q.st),
        .mask             (ctrl_q.mask),
        .rd_sector        (rd_sector),
        .ready            (ready),
        .rd_status_sel    (rd_status_sel),
        .stat_window_done (stat_window_done),
        .stat_erasing     (stat_erasing),
        .stat_suspended   (stat_suspended)
    );

    AST_MISMATCH_UNL1: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_q.st == ST_UNL1 && wr_en && !(cmd.at_b && cmd.d_55)) |=> (ctrl_q.st == ST_IDLE)); // R3
    AST_MISMATCH_UNL2: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_q.st == ST_UNL2 && wr_en && !(cmd.at_a && cmd.d_80)) |=> (ctrl_q.st == ST_IDLE)); // R3
    AST_ERASE_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_q.st == ST_ERASE && $past(ctrl_q.st == ST_ERASE)) |-> $stable(erase_mask)); // R6
    AST_WIN_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_q.st == ST_WINDOW && wr_en && cmd.d_b0) |=> (stat_suspended && ready)); // R7
    AST_CHIP_NO_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_q.st == ST_CHIP) |=> !stat_suspended); // R12
    AST_IDLE_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_q.st == ST_IDLE) |-> (erase_mask == '0)); // R11
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) $fell(stat_window_done) && !stat_suspended |-> (erase_mask == '0)); // R11

endmodule

// File: tb/flash_sector_erase_ctrl_tb.sv
module flash_sector_erase_ctrl_tb;

    localparam int NUM_SECT  = 8;
    localparam int SEC_W     = 3;
    localparam int WIN_CYC   = 40;
    localparam int ERASE_CYC = 200;
    localparam int SUSP_LAT  = 8;
    localparam int NVEC      = 22;

    // {addr[13:0], data[7:0], expected mask[7:0], expected ready}
    localparam logic [30:0] VEC [NVEC] = '{
        {14'h0555, 8'hAA, 8'h00, 1'b1},
        {14'h02AA, 8'h55, 8'h00, 1'b1},
        {14'h0555, 8'h80, 8'h00, 1'b1},
        {14'h0555, 8'hAA, 8'h00, 1'b1},
        {14'h02AA, 8'h55, 8'h00, 1'b1},
        {14'h1000, 8'h30, 8'h04, 1'b1},
        {14'h2800, 8'h30, 8'h24, 1'b1},
        {14'h0123, 8'h30, 8'h25, 1'b1},
        {14'h3800, 8'h30, 8'hA5, 1'b1},
        {14'h0555, 8'hF0, 8'h00, 1'b1},
        {14'h0555, 8'hAA, 8'h00, 1'b1},
        {14'h02AA, 8'h56, 8'h00, 1'b1},
        {14'h0555, 8'h80, 8'h00, 1'b1},
        {14'h0555, 8'hAA, 8'h00, 1'b1},
        {14'h02AA, 8'h55, 8'h00, 1'b1},
        {14'h1000, 8'h30, 8'h00, 1'b1},
        {14'h0555, 8'hAA, 8'h00, 1'b1},
        {14'h02AA, 8'h55, 8'h00, 1'b1},
        {14'h0555, 8'h80, 8'h00, 1'b1},
        {14'h0556, 8'hAA, 8'h00, 1'b1},
        {14'h02AA, 8'h55, 8'h00, 1'b1},
        {14'h1000, 8'h30, 8'h00, 1'b1}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                wr_en = 1'b0;
    logic [13:0]         wr_addr = '0;
    logic [7:0]          wr_data = '0;
    logic [SEC_W-1:0]    rd_sector = '0;
    logic                ready;
    logic [NUM_SECT-1:0] erase_mask;
    logic                rd_status_sel;
    logic                stat_window_done;
    logic                stat_erasing;
    logic                stat_suspended;

    int   n_chk = 0;
    int   n_fail = 0;
    int   er_cycles = 0;
    logic cnt_clr = 1'b0;

    always #2.5 clk = ~clk;

    flash_sector_erase_ctrl #(
        .NUM_SECT  (NUM_SECT),
        .SEC_W     (SEC_W),
        .WIN_CYC   (WIN_CYC),
        .ERASE_CYC (ERASE_CYC),
        .SUSP_LAT  (SUSP_LAT)
    ) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en            (wr_en),
        .wr_addr          (wr_addr),
        .wr_data          (wr_data),
        .rd_sector        (rd_sector),
        .ready            (ready),
        .erase_mask       (erase_mask),
        .rd_status_sel    (rd_status_sel),
        .stat_window_done (stat_window_done),
        .stat_erasing     (stat_erasing),
        .stat_suspended   (stat_suspended)
    );

    // counts cycles that hold stat_erasing high (pre-edge value)
    always @(posedge clk) begin
        if (cnt_clr) er_cycles <= 0;
        else if (stat_erasing) er_cycles <= er_cycles + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic open_seq(input logic [13:0] last_addr, input logic [7:0] last_data);
        wr(14'h0555, 8'hAA);
        wr(14'h02AA, 8'h55);
        wr(14'h0555, 8'h80);
        wr(14'h0555, 8'hAA);
        wr(14'h02AA, 8'h55);
        wr(last_addr, last_data);
    endtask

    task automatic clear_count();
        @(negedge clk);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 5000 && !ready; i++) @(negedge clk);
    endtask

    task automatic wait_busy();
        for (int i = 0; i < 5000 && ready; i++) @(negedge clk);
    endtask

    task automatic report();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", ready, 1);
        chk("R1 mask", erase_mask, 0);
        chk("R1 status", {stat_window_done, stat_erasing, stat_suspended, rd_status_sel}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // vector walk: R2 sequence, R4 adding sectors, R5 abort, R3 mismatches
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][30:17], VEC[i][16:9]);
            chk("R2 R3 R4 R5 vector mask", erase_mask, VEC[i][8:1]);
            chk("R2 R3 R5 vector ready", ready, VEC[i][0]);
        end

        // R4 window restart and exact expiry
        clear_count();
        open_seq(14'h1800, 8'h30);
        chk("R2 window not expired", stat_window_done, 0);
        repeat (WIN_CYC - 4) @(negedge clk);
        wr(14'h0800, 8'h30);
        chk("R4 sector added", erase_mask, 8'h0A);
        repeat (WIN_CYC - 1) @(negedge clk);
        chk("R4 still open after restart", ready, 1);
        @(negedge clk);
        chk("R4 busy at expiry", ready, 0);
        chk("R4 window done", stat_window_done, 1);
        chk("R4 erasing", stat_erasing, 1);
        // R6 writes ignored during erase
        wr(14'h0555, 8'hF0);
        wr(14'h2000, 8'h30);
        chk("R6 mask kept", erase_mask, 8'h0A);
        chk("R6 still busy", ready, 0);
        // R9 read select
        rd_sector = 3'd3;
        #1 chk("R9 selected sector status", rd_status_sel, 1);
        rd_sector = 3'd4;
        #1 chk("R9 other sector array", rd_status_sel, 0);
        wait_ready();
        chk("R10 uninterrupted length", er_cycles, ERASE_CYC);
        chk("R11 mask released", erase_mask, 0);
        chk("R11 status clear", {stat_window_done, stat_erasing, stat_suspended}, 0);

        // R7 suspend in window, then R10 resume
        clear_count();
        open_seq(14'h3000, 8'h30);
        wr(14'h1234, 8'hB0);
        chk("R7 suspended", stat_suspended, 1);
        chk("R7 ready", ready, 1);
        chk("R7 window done", stat_window_done, 1);
        chk("R7 not erasing", stat_erasing, 0);
        rd_sector = 3'd6;
        #1 chk("R9 suspended selected", rd_status_sel, 1);
        rd_sector = 3'd1;
        #1 chk("R9 suspended unselected", rd_status_sel, 0);
        repeat (10) @(negedge clk);
        chk("R10 frozen while suspended", er_cycles, 0);
        wr(14'h0000, 8'h30);
        chk("R10 resumed busy", ready, 0);
        wait_ready();
        chk("R10 full length after resume", er_cycles, ERASE_CYC);

        // R8 suspend during running erase
        clear_count();
        open_seq(14'h2000, 8'h30);
        wait_busy();
        repeat (20) @(negedge clk);
        wr(14'h0001, 8'hB0);
        repeat (SUSP_LAT - 1) @(negedge clk);
        chk("R8 busy during latency", ready, 0);
        chk("R8 not yet suspended", stat_suspended, 0);
        @(negedge clk);
        chk("R8 suspended after latency", stat_suspended, 1);
        chk("R8 ready when suspended", ready, 1);
        wr(14'h0000, 8'h30);
        wait_ready();
        chk("R10 split erase length", er_cycles, ERASE_CYC);
        chk("R11 mask after split erase", erase_mask, 0);

        // R12 chip erase
        clear_count();
        open_seq(14'h0555, 8'h10);
        chk("R12 busy immediately", ready, 0);
        chk("R12 all sectors", erase_mask, 8'hFF);
        wr(14'h0000, 8'hB0);
        repeat (SUSP_LAT + 2) @(negedge clk);
        chk("R12 suspend ignored", stat_suspended, 0);
        chk("R12 still busy", ready, 0);
        wait_ready();
        chk("R12 chip length", er_cycles, ERASE_CYC);

        // R13 reset aborts erase
        open_seq(14'h0555, 8'h10);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R13 ready at reset", ready, 1);
        chk("R13 mask at reset", erase_mask, 0);
        chk("R13 erasing at reset", stat_erasing, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        report();
    end

endmodule